// File: doc/BRIEF.md
# Output-Voltage Status Register

This block watches a stream of digitized output-voltage samples and compares each valid sample against overvoltage and undervoltage limits. It records faults and warnings as sticky bits in a one-byte status register. It also records a warning raised by the setpoint logic whenever a requested output level had to be clamped. Once a bit is captured it stays set after the condition goes away. Only an explicit clear removes it: a write of one to that bit, a global clear strobe, a toggle of the rail's on/off control, or reset.

The block drives three outputs. The first is the status byte itself, for a register-read path. The second is a summary flag that a higher-level status word can use. The third is an active-low, registered alert request that fires only for set bits left unmasked by a per-bit mask. The overvoltage fault can be detected against a relative limit alone, or also against an absolute limit selected at run time. A parameter can remove the absolute path entirely.

Top module: `vout_status_reg`

## Requirements
- R1: After reset the status byte reads 8'h00, the summary flag is 0 and the alert output is 1.
- R2: A status bit stays set after its triggering condition is gone, until one of the clear paths acts on it.
- R3: When the byte write strobe is high, each of bits 7..3 whose written data bit is 1 clears, and each bit written with 0 keeps its value.
- R4: Bits 2..0 are reserved: they always read 0, and writes do not affect them.
- R5: A clear-all strobe, or an on/off toggle event, clears all of bits 7..3 on the next clock edge.
- R6: Bit 7 (overvoltage fault) sets when a valid sample is strictly greater than the relative fault limit. It also sets when the absolute select input is 1 and the sample is strictly greater than the absolute limit.
- R7: Bit 6 (overvoltage warning) sets when a valid sample exceeds the warning limit. Bit 5 (undervoltage warning) sets when a valid sample is strictly below its limit. Bit 4 (undervoltage fault) sets when a valid sample is strictly below its limit. No comparison takes effect when the valid strobe is low.
- R8: Whenever bit 4 is set, bit 5 is set too, even if a write tries to clear bit 5 alone.
- R9: Bit 3 (clamp warning) sets on a clamp event from the setpoint logic.
- R10: If a set condition and a clear request hit the same bit in the same cycle, the bit ends up set.
- R11: The summary flag is 1 exactly when any status bit is set.
- R12: The alert output is registered and active-low. It goes to 0 one clock after the status byte holds a set bit whose mask bit is 0, and returns to 1 one clock after no such bit remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | SAMPLE_W | Output-voltage sample |
| smp_valid | input | 1 | Sample valid strobe |
| ov_fault_lim | input | SAMPLE_W | Relative overvoltage fault limit |
| ov_warn_lim | input | SAMPLE_W | Overvoltage warning limit |
| uv_warn_lim | input | SAMPLE_W | Undervoltage warning limit |
| uv_fault_lim | input | SAMPLE_W | Undervoltage fault limit |
| abs_ov_lim | input | SAMPLE_W | Absolute overvoltage limit |
| abs_ov_sel | input | 1 | Enables the absolute overvoltage comparison |
| clamp_evt | input | 1 | Setpoint was clamped by the maximum setting |
| clear_all | input | 1 | Clear-all strobe |
| onoff_toggle | input | 1 | Rail on/off toggle event |
| wr_en | input | 1 | Status byte write strobe |
| wr_data | input | 8 | Write data, ones clear bits |
| alert_mask | input | 8 | Per-bit alert mask, 1 masks |
| status_byte | output | 8 | Status register contents |
| summary | output | 1 | OR of all status bits |
| alert_n | output | 1 | Registered active-low alert request |

## Verification
A sample, clamp event, write or clear presented before a clock edge shows up in the status byte and the summary flag right after that same edge. The alert output lags by one further edge. The bench drives inputs and samples outputs one time unit after each rising edge. It reads status and summary after one edge, and it reads the alert after two edges. It also reads the alert after only one edge, to confirm that the extra register stage exists.

// File: rtl/vstat_pkg.sv
package vstat_pkg;
   localparam int STAT_W = 8;
   localparam int B_OVF  = 7;
   localparam int B_OVW  = 6;
   localparam int B_UVW  = 5;
   localparam int B_UVF  = 4;
   localparam int B_CLW  = 3;
   localparam logic [STAT_W-1:0] LIVE_BITS = 8'hF8;
endpackage

// File: rtl/vstat_cmp.sv
module vstat_cmp
   import vstat_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter bit ABS_OV_EN = 1'b1
) (
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] ov_fault_lim,
   input  logic [SAMPLE_W-1:0] ov_warn_lim,
   input  logic [SAMPLE_W-1:0] uv_warn_lim,
   input  logic [SAMPLE_W-1:0] uv_fault_lim,
   input  logic [SAMPLE_W-1:0] abs_ov_lim,
   input  logic                abs_ov_sel,
   input  logic                clamp_evt,
   output logic [STAT_W-1:0]   set_vec
);
   logic abs_hit;

   generate
      if (ABS_OV_EN) begin : g_abs
         assign abs_hit = abs_ov_sel && (smp_data > abs_ov_lim);
      end else begin : g_noabs
         assign abs_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      set_vec        = '0;
      set_vec[B_OVF] = smp_valid && ((smp_data > ov_fault_lim) || abs_hit);
      set_vec[B_OVW] = smp_valid && (smp_data > ov_warn_lim);
      set_vec[B_UVW] = smp_valid && (smp_data < uv_warn_lim);
      set_vec[B_UVF] = smp_valid && (smp_data < uv_fault_lim);
      set_vec[B_CLW] = clamp_evt;
   end
endmodule

// File: rtl/vstat_latch.sv
module vstat_latch
   import vstat_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] set_vec,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] wr_data,
   input  logic              clear_all,
   input  logic              onoff_toggle,
   output logic [STAT_W-1:0] status_q
);
   logic [STAT_W-1:0] clr_vec;
   logic [STAT_W-1:0] nxt_raw;
   logic [STAT_W-1:0] nxt;

   always_comb begin
      clr_vec = (wr_en ? wr_data : '0) | {STAT_W{clear_all | onoff_toggle}};
      nxt_raw = (set_vec | (status_q & ~clr_vec)) & LIVE_BITS;
      nxt     = nxt_raw;
      nxt[B_UVW] = nxt_raw[B_UVW] | nxt_raw[B_UVF];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= nxt;
   end
endmodule

// File: rtl/vstat_alert.sv
module vstat_alert
   import vstat_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] status_q,
   input  logic [STAT_W-1:0] alert_mask,
   output logic              alert_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alert_n <= 1'b1;
      else        alert_n <= ~|(status_q & ~alert_mask);
   end
endmodule

// File: rtl/vout_status_reg.sv
module vout_status_reg
   import vstat_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter bit ABS_OV_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] ov_fault_lim,
   input  logic [SAMPLE_W-1:0] ov_warn_lim,
   input  logic [SAMPLE_W-1:0] uv_warn_lim,
   input  logic [SAMPLE_W-1:0] uv_fault_lim,
   input  logic [SAMPLE_W-1:0] abs_ov_lim,
   input  logic                abs_ov_sel,
   input  logic                clamp_evt,
   input  logic                clear_all,
   input  logic                onoff_toggle,
   input  logic                wr_en,
   input  logic [7:0]          wr_data,
   input  logic [7:0]          alert_mask,
   output logic [7:0]          status_byte,
   output logic                summary,
   output logic                alert_n
);
   generate
      if (SAMPLE_W < 2 || SAMPLE_W > 32) begin : g_bad_width
         $error("vout_status_reg: SAMPLE_W must lie in 2..32");
      end
      if (STAT_W != 8) begin : g_bad_stat
         $error("vout_status_reg: status width must be one byte");
      end
   endgenerate

   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] status_q;

   vstat_cmp #(.SAMPLE_W(SAMPLE_W), .ABS_OV_EN(ABS_OV_EN)) u_cmp (
      .smp_data     (smp_data),
      .smp_valid    (smp_valid),
      .ov_fault_lim (ov_fault_lim),
      .ov_warn_lim  (ov_warn_lim),
      .uv_warn_lim  (uv_warn_lim),
      .uv_fault_lim (uv_fault_lim),
      .abs_ov_lim   (abs_ov_lim),
      .abs_ov_sel   (abs_ov_sel),
      .clamp_evt    (clamp_evt),
      .set_vec      (set_vec)
   );

   vstat_latch u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_vec      (set_vec),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .clear_all    (clear_all),
      .onoff_toggle (onoff_toggle),
      .status_q     (status_q)
   );

   vstat_alert u_alert (
      .clk        (clk),
      .rst_n      (rst_n),
      .status_q   (status_q),
      .alert_mask (alert_mask),
      .alert_n    (alert_n)
   );

   assign status_byte = status_q;
   assign summary     = |status_q;
endmodule

// File: rtl/vout_status_chk.sv
module vout_status_chk #(
   parameter int SAMPLE_W = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic [SAMPLE_W-1:0] smp_data,
   input logic                smp_valid,
   input logic [SAMPLE_W-1:0] ov_fault_lim,
   input logic                clamp_evt,
   input logic                clear_all,
   input logic                onoff_toggle,
   input logic                wr_en,
   input logic [7:0]          wr_data,
   input logic [7:0]          alert_mask,
   input logic [7:0]          status_byte,
   input logic                summary,
   input logic                alert_n
);
   assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[2:0] == 3'b000);

   assert_uvf_forces_uvw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[4] |-> status_byte[5]);

   assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (status_byte[7] && !clear_all && !onoff_toggle && !(wr_en && wr_data[7]))
      |=> status_byte[7]);

   assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((clear_all || onoff_toggle) && !smp_valid && !clamp_evt)
      |=> (status_byte[7:3] == 5'b0));

   assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && (smp_data > ov_fault_lim)) |=> status_byte[7]);

   assert_clamp_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_evt |=> status_byte[3]);

   assert_summary_R11: assert property (@(posedge clk) disable iff (!rst_n)
      summary == (status_byte != 8'h00));

   assert_alert_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_byte & ~alert_mask) != 8'h00) |=> !alert_n);

   assert_alert_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_byte & ~alert_mask) == 8'h00) |=> alert_n);
endmodule

bind vout_status_reg vout_status_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/vout_status_reg_tb.sv
`timescale 1ns/1ps
module vout_status_reg_tb;
   localparam int W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] smp_data = '0;
   logic smp_valid = 1'b0;
   logic [W-1:0] ov_fault_lim = 12'd3000;
   logic [W-1:0] ov_warn_lim  = 12'd2800;
   logic [W-1:0] uv_warn_lim  = 12'd1200;
   logic [W-1:0] uv_fault_lim = 12'd1000;
   logic [W-1:0] abs_ov_lim   = 12'd2850;
   logic abs_ov_sel = 1'b0;
   logic clamp_evt = 1'b0;
   logic clear_all = 1'b0;
   logic onoff_toggle = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] alert_mask = 8'hFF;
   logic [7:0] status_byte;
   logic summary;
   logic alert_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vout_status_reg u_dut (.*);

   // sample value, expected status after one edge
   localparam logic [19:0] VEC [0:7] = '{
      {12'd2000, 8'h00}, {12'd2900, 8'h40}, {12'd3000, 8'h40}, {12'd3001, 8'hC0},
      {12'd1100, 8'h20}, {12'd999,  8'h30}, {12'd1000, 8'h20}, {12'd1200, 8'h00}};

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic sample(logic [W-1:0] v);
      smp_data = v; smp_valid = 1'b1; cyc(); smp_valid = 1'b0;
   endtask

   task automatic write(logic [7:0] d);
      wr_data = d; wr_en = 1'b1; cyc(); wr_en = 1'b0;
   endtask

   task automatic clr();
      clear_all = 1'b1; cyc(); clear_all = 1'b0;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      cyc(); cyc();
      chk("R1 status", status_byte, 8'h00);
      chk("R1 summary", {7'b0, summary}, 8'h00);
      chk("R1 alert_n", {7'b0, alert_n}, 8'h01);
      rst_n = 1'b1; cyc();

      // R6 R7 threshold table
      for (int i = 0; i < 8; i++) begin
         sample(VEC[i][19:8]);
         chk("R6/R7 vector", status_byte, VEC[i][7:0]);
         clr();
      end

      // R7 valid low ignored
      smp_data = 12'd3500; smp_valid = 1'b0; cyc();
      chk("R7 invalid sample", status_byte, 8'h00);

      // R6 absolute limit selected / not selected
      abs_ov_sel = 1'b1; sample(12'd2900);
      chk("R6 absolute", status_byte, 8'hC0);
      clr(); abs_ov_sel = 1'b0;
      sample(12'd2900);
      chk("R6 absolute off", status_byte, 8'h40);

      // R2 sticky
      sample(12'd2000); cyc(); cyc();
      chk("R2 sticky", status_byte, 8'h40);
      clr();

      // R3 write-one-to-clear
      sample(12'd3100);
      chk("R3 setup", status_byte, 8'hC0);
      write(8'h40);
      chk("R3 clear bit6", status_byte, 8'h80);
      write(8'h00);
      chk("R3 zero write", status_byte, 8'h80);
      write(8'hFF);
      chk("R3 clear all by write", status_byte, 8'h00);
      chk("R11 summary low", {7'b0, summary}, 8'h00);

      // R4 reserved
      write(8'h07);
      chk("R4 reserved", status_byte, 8'h00);

      // R8 link
      sample(12'd900);
      chk("R8 setup", status_byte, 8'h30);
      write(8'h20);
      chk("R8 uvw held", status_byte, 8'h30);
      write(8'h10);
      chk("R8 uvf cleared", status_byte, 8'h20);

      // R5 toggle clear
      onoff_toggle = 1'b1; cyc(); onoff_toggle = 1'b0;
      chk("R5 toggle", status_byte, 8'h00);
      sample(12'd3100); clr();
      chk("R5 clear_all", status_byte, 8'h00);

      // R9 clamp, R11 summary
      clamp_evt = 1'b1; cyc(); clamp_evt = 1'b0;
      chk("R9 clamp", status_byte, 8'h08);
      chk("R11 summary high", {7'b0, summary}, 8'h01);

      // R10 set wins
      clamp_evt = 1'b1; clear_all = 1'b1; cyc(); clamp_evt = 1'b0; clear_all = 1'b0;
      chk("R10 clear_all vs set", status_byte, 8'h08);
      clamp_evt = 1'b1; wr_data = 8'h08; wr_en = 1'b1; cyc();
      clamp_evt = 1'b0; wr_en = 1'b0;
      chk("R10 write vs set", status_byte, 8'h08);
      clr();

      // R12 alert timing and masking
      cyc();
      alert_mask = 8'hF7;
      clamp_evt = 1'b1; cyc(); clamp_evt = 1'b0;
      chk("R12 alert one edge", {7'b0, alert_n}, 8'h01);
      cyc();
      chk("R12 alert low", {7'b0, alert_n}, 8'h00);
      write(8'h08);
      chk("R12 alert still low", {7'b0, alert_n}, 8'h00);
      cyc();
      chk("R12 alert released", {7'b0, alert_n}, 8'h01);
      sample(12'd2900); cyc();
      chk("R12 masked bit", {7'b0, alert_n}, 8'h01);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule